// File: doc/BRIEF.md
# Banked Per-Core Timer Register Router

This block sits between a shared 32-bit register bus and a set of private timer register banks, one bank per processor core. The number of cores is a parameter between one and a fixed ceiling. The block splits its address space into windows of 32 bytes each. The lowest window is a "this core" alias: it is steered by the core-ID input that comes with each access, so every core uses the same address to reach its own timer. The windows above it map straight onto the banks of core 0, core 1 and onward, so any core can reach any other core's timer.

For a legal access the router raises exactly one read or write strobe toward the chosen bank. It forwards the 5-bit register offset and the write data, and it returns that bank's read data in the same cycle. An access is illegal when it is not a full, aligned 32-bit word, when it targets a window above the last core, or when it uses the alias from a core ID the system does not have. Such an access strobes no bank and reads as zero. It is also flagged on an error output in the following cycle. Each bank's interrupt line is passed out in core order.

Top module: `tmr_bank_router`

## Requirements
- R1: An access to window 0 (address bits above bit 4 equal to zero) from core ID c, with c below NUM_CORES, strobes bank c only.
- R2: An access to window k, for k from 1 to NUM_CORES, strobes bank k-1 only, whatever the core ID.
- R3: The bank offset output always equals address bits [4:0], and the bank write data output always equals the bus write data.
- R4: A legal access raises exactly one strobe. It is a read strobe when the write-enable input is low and a write strobe when it is high.
- R5: During a legal read the read data output equals the selected bank's read data in the same cycle. In every other case it is zero.
- R6: An alias access (window 0) from a core ID of NUM_CORES or above raises no strobe and reads zero.
- R7: An access to a window above NUM_CORES raises no strobe and reads zero.
- R8: An access whose byte enables are not all four set (4'hF), or whose address bits [1:0] are not zero, raises no strobe and reads zero.
- R9: The error output is high in the cycle after an illegal access. It is low after a legal access or an idle cycle, and low during and right after reset.
- R10: Interrupt output bit i always equals the interrupt input from bank i.
- R11: While the select input is low, no strobe is raised and the read data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the error response register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_sel_i | input | 1 | Access request this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address within the router's space |
| bus_be_i | input | 4 | Byte enables; only 4'hF is legal |
| bus_core_i | input | CORE_ID_W | ID of the requesting core |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, same cycle |
| bus_err_o | output | 1 | Illegal-access flag, one cycle after the access |
| bank_rd_o | output | NUM_CORES | Per-bank read strobe |
| bank_wr_o | output | NUM_CORES | Per-bank write strobe |
| bank_off_o | output | 5 | Register offset within the bank |
| bank_wdata_o | output | 32 | Write data to the banks |
| bank_rdata_i | input | NUM_CORES*32 | Read data of all banks, bank 0 in the low word |
| bank_irq_i | input | NUM_CORES | Interrupt line of each bank |
| irq_o | output | NUM_CORES | Interrupt lines, core 0 in bit 0 |

## Verification
A wrong window or alias decode shows up in the same cycle as a strobe on the wrong bank, or as read data from the wrong bank. The bench gives every bank a distinct read word, so a misroute is visible at once. A faulty legality decode shows as a strobe during an illegal access or as nonzero read data. The error output then disagrees one cycle later, because that is its only stored state. Alias accesses from the same address with different core IDs, and direct windows from mismatched core IDs, separate the two routing paths.

// File: rtl/tmr_router_pkg.sv
package tmr_router_pkg;
   localparam int MAX_CORES = 8;
   localparam int CORE_ID_W = 3;
   localparam int WORD_W    = 32;
   localparam int OFF_W     = 5;
   localparam int BE_W      = 4;
   localparam logic [BE_W-1:0] FULL_BE = '1;

   typedef logic [WORD_W-1:0] word_t;
   typedef logic [OFF_W-1:0]  off_t;
endpackage

// File: rtl/tmr_win_decode.sv
module tmr_win_decode
   import tmr_router_pkg::*;
#(
   parameter int ADDR_W = 9,
   localparam int WIN_W = ADDR_W - OFF_W
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [BE_W-1:0]   be_i,
   output logic [WIN_W-1:0]  win_o,
   output off_t              off_o,
   output logic              word_ok_o
);
   assign win_o     = addr_i[ADDR_W-1:OFF_W];
   assign off_o     = addr_i[OFF_W-1:0];
   assign word_ok_o = (be_i == FULL_BE) && (addr_i[1:0] == 2'b00);
endmodule

// File: rtl/tmr_bank_select.sv
module tmr_bank_select
   import tmr_router_pkg::*;
#(
   parameter int NUM_CORES = 4,
   parameter int WIN_W     = 4
) (
   input  logic                 sel_i,
   input  logic                 we_i,
   input  logic                 word_ok_i,
   input  logic [WIN_W-1:0]     win_i,
   input  logic [CORE_ID_W-1:0] core_i,
   output logic [NUM_CORES-1:0] rd_o,
   output logic [NUM_CORES-1:0] wr_o,
   output logic                 bad_o
);
   logic [NUM_CORES-1:0] match;
   logic                 alias_win;
   logic                 legal;

   assign alias_win = (win_i == '0);

   for (genvar gi = 0; gi < NUM_CORES; gi++) begin : g_match
      logic direct_hit;
      logic alias_hit;
      assign direct_hit = (win_i == WIN_W'(gi + 1));
      assign alias_hit  = alias_win && (core_i == CORE_ID_W'(gi));
      assign match[gi]  = direct_hit || alias_hit;
   end

   assign legal = sel_i && word_ok_i && (|match);
   assign rd_o  = (legal && !we_i) ? match : '0;
   assign wr_o  = (legal &&  we_i) ? match : '0;
   assign bad_o = sel_i && !legal;
endmodule

// File: rtl/tmr_rdata_mux.sv
module tmr_rdata_mux
   import tmr_router_pkg::*;
#(
   parameter int NUM_CORES = 4
) (
   input  logic [NUM_CORES-1:0]        rd_i,
   input  logic [NUM_CORES*WORD_W-1:0] bank_rdata_i,
   output word_t                       rdata_o
);
   if (NUM_CORES == 1) begin : g_single
      assign rdata_o = rd_i[0] ? bank_rdata_i : '0;
   end else begin : g_andor
      always_comb begin
         rdata_o = '0;
         for (int i = 0; i < NUM_CORES; i++) begin
            rdata_o |= bank_rdata_i[i*WORD_W +: WORD_W] & {WORD_W{rd_i[i]}};
         end
      end
   end
endmodule

// File: rtl/tmr_bank_router.sv
module tmr_bank_router
   import tmr_router_pkg::*;
#(
   parameter int NUM_CORES = 4,
   parameter int ADDR_W    = 9
) (
   input  logic                        clk_i,
   input  logic                        rst_ni,
   input  logic                        bus_sel_i,
   input  logic                        bus_we_i,
   input  logic [ADDR_W-1:0]           bus_addr_i,
   input  logic [BE_W-1:0]             bus_be_i,
   input  logic [CORE_ID_W-1:0]        bus_core_i,
   input  logic [WORD_W-1:0]           bus_wdata_i,
   output logic [WORD_W-1:0]           bus_rdata_o,
   output logic                        bus_err_o,
   output logic [NUM_CORES-1:0]        bank_rd_o,
   output logic [NUM_CORES-1:0]        bank_wr_o,
   output logic [OFF_W-1:0]            bank_off_o,
   output logic [WORD_W-1:0]           bank_wdata_o,
   input  logic [NUM_CORES*WORD_W-1:0] bank_rdata_i,
   input  logic [NUM_CORES-1:0]        bank_irq_i,
   output logic [NUM_CORES-1:0]        irq_o
);
   localparam int WIN_W = ADDR_W - OFF_W;

   if (NUM_CORES < 1 || NUM_CORES > MAX_CORES) begin : g_bad_cores
      $error("NUM_CORES must lie in 1..MAX_CORES");
   end
   if (WIN_W < 1 || (2 ** WIN_W) < NUM_CORES + 1) begin : g_bad_addr
      $error("ADDR_W too narrow for NUM_CORES+1 windows");
   end

   logic [WIN_W-1:0] win;
   logic             word_ok;
   logic             bad;
   logic             err_q;

   tmr_win_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr_i    (bus_addr_i),
      .be_i      (bus_be_i),
      .win_o     (win),
      .off_o     (bank_off_o),
      .word_ok_o (word_ok)
   );

   tmr_bank_select #(.NUM_CORES(NUM_CORES), .WIN_W(WIN_W)) u_sel (
      .sel_i     (bus_sel_i),
      .we_i      (bus_we_i),
      .word_ok_i (word_ok),
      .win_i     (win),
      .core_i    (bus_core_i),
      .rd_o      (bank_rd_o),
      .wr_o      (bank_wr_o),
      .bad_o     (bad)
   );

   tmr_rdata_mux #(.NUM_CORES(NUM_CORES)) u_mux (
      .rd_i         (bank_rd_o),
      .bank_rdata_i (bank_rdata_i),
      .rdata_o      (bus_rdata_o)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) err_q <= 1'b0;
      else         err_q <= bad;
   end

   assign bus_err_o    = err_q;
   assign bank_wdata_o = bus_wdata_i;
   assign irq_o        = bank_irq_i;
endmodule

// File: rtl/tmr_bank_router_chk.sv
module tmr_bank_router_chk
   import tmr_router_pkg::*;
#(
   parameter int NUM_CORES = 4,
   parameter int ADDR_W    = 9
) (
   input logic                        clk_i,
   input logic                        rst_ni,
   input logic                        bus_sel_i,
   input logic                        bus_we_i,
   input logic [ADDR_W-1:0]           bus_addr_i,
   input logic [BE_W-1:0]             bus_be_i,
   input logic [CORE_ID_W-1:0]        bus_core_i,
   input logic [WORD_W-1:0]           bus_wdata_i,
   input logic [WORD_W-1:0]           bus_rdata_o,
   input logic                        bus_err_o,
   input logic [NUM_CORES-1:0]        bank_rd_o,
   input logic [NUM_CORES-1:0]        bank_wr_o,
   input logic [OFF_W-1:0]            bank_off_o,
   input logic [WORD_W-1:0]           bank_wdata_o,
   input logic [NUM_CORES*WORD_W-1:0] bank_rdata_i,
   input logic [NUM_CORES-1:0]        bank_irq_i,
   input logic [NUM_CORES-1:0]        irq_o
);
   localparam int WIN_W = ADDR_W - OFF_W;

   logic [WIN_W-1:0]     win;
   logic                 ill;
   int                   tgt;
   logic [NUM_CORES-1:0] strobes;

   assign win     = bus_addr_i[ADDR_W-1:OFF_W];
   assign strobes = bank_rd_o | bank_wr_o;

   always_comb begin
      ill = (bus_be_i != 4'hF) || (bus_addr_i[1:0] != 2'b00) ||
            (int'(win) > NUM_CORES) ||
            ((win == '0) && (int'(bus_core_i) >= NUM_CORES));
      tgt = (win == '0) ? int'(bus_core_i) : int'(win) - 1;
   end

   a_r1_r2_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_sel_i && !ill) |-> strobes[tgt]);
   a_r3_forward: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bank_off_o == bus_addr_i[4:0]) && (bank_wdata_o == bus_wdata_i));
   a_r4_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_sel_i && !ill) |-> ($countones({bank_rd_o, bank_wr_o}) == 1));
   a_r4_direction: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((bus_we_i ? bank_rd_o : bank_wr_o) == '0));
   a_r5_rdata: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_sel_i && !ill && !bus_we_i) |-> (bus_rdata_o == bank_rdata_i[tgt*WORD_W +: WORD_W]));
   a_r5_zero_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bus_we_i |-> (bus_rdata_o == '0));
   a_r8_illegal_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_sel_i && ill) |-> ((strobes == '0) && (bus_rdata_o == '0)));
   a_r9_err_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_sel_i && ill) |=> bus_err_o);
   a_r9_err_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(bus_sel_i && ill) |=> !bus_err_o);
   a_r10_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o == bank_irq_i);
   a_r11_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !bus_sel_i |-> ($onehot0(strobes) && (strobes == '0) && (bus_rdata_o == '0)));
endmodule

bind tmr_bank_router tmr_bank_router_chk #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W)) chk_i (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .bus_sel_i    (bus_sel_i),
   .bus_we_i     (bus_we_i),
   .bus_addr_i   (bus_addr_i),
   .bus_be_i     (bus_be_i),
   .bus_core_i   (bus_core_i),
   .bus_wdata_i  (bus_wdata_i),
   .bus_rdata_o  (bus_rdata_o),
   .bus_err_o    (bus_err_o),
   .bank_rd_o    (bank_rd_o),
   .bank_wr_o    (bank_wr_o),
   .bank_off_o   (bank_off_o),
   .bank_wdata_o (bank_wdata_o),
   .bank_rdata_i (bank_rdata_i),
   .bank_irq_i   (bank_irq_i),
   .irq_o        (irq_o)
);

// File: tb/tmr_bank_router_tb_top.sv
module tmr_bank_router_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NC = 4;
   localparam int AW = 9;

   typedef struct packed {
      logic       sel;
      logic       we;
      logic [8:0] addr;
      logic [3:0] be;
      logic [2:0] core;
      logic [3:0] bank;   // 4'hF = no bank
      logic       err;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 1'b0, 9'h004, 4'hF, 3'd0, 4'd0, 1'b0},  // R1 alias core0
      '{1'b1, 1'b0, 9'h00C, 4'hF, 3'd3, 4'd3, 1'b0},  // R1 alias core3
      '{1'b1, 1'b1, 9'h008, 4'hF, 3'd2, 4'd2, 1'b0},  // R1 alias write
      '{1'b1, 1'b0, 9'h020, 4'hF, 3'd3, 4'd0, 1'b0},  // R2 win1 from core3
      '{1'b1, 1'b0, 9'h08C, 4'hF, 3'd0, 4'd3, 1'b0},  // R2 win4 (last)
      '{1'b1, 1'b1, 9'h074, 4'hF, 3'd1, 4'd2, 1'b0},  // R2 win3 write
      '{1'b1, 1'b0, 9'h010, 4'hF, 3'd4, 4'hF, 1'b1},  // R6 core = N
      '{1'b1, 1'b1, 9'h000, 4'hF, 3'd7, 4'hF, 1'b1},  // R6 core 7 write
      '{1'b1, 1'b0, 9'h0A0, 4'hF, 3'd0, 4'hF, 1'b1},  // R7 win N+1
      '{1'b1, 1'b1, 9'h1E0, 4'hF, 3'd1, 4'hF, 1'b1},  // R7 top window
      '{1'b1, 1'b0, 9'h048, 4'h3, 3'd0, 4'hF, 1'b1},  // R8 half word
      '{1'b1, 1'b1, 9'h042, 4'hF, 3'd0, 4'hF, 1'b1},  // R8 misaligned
      '{1'b0, 1'b0, 9'h020, 4'hF, 3'd0, 4'hF, 1'b0},  // R11 idle
      '{1'b1, 1'b0, 9'h05C, 4'hF, 3'd6, 4'd1, 1'b0}   // R2 win2, core id out of range
   };

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 sel = 1'b0, we = 1'b0;
   logic [AW-1:0]        addr = '0;
   logic [3:0]           be = 4'hF;
   logic [2:0]           core = '0;
   logic [31:0]          wdata = '0;
   logic [31:0]          rdata;
   logic                 err;
   logic [NC-1:0]        rd, wr, irq_in = '0, irq_out;
   logic [4:0]           off;
   logic [31:0]          bwdata;
   logic [NC*32-1:0]     brdata;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   always_comb begin
      for (int i = 0; i < NC; i++) brdata[i*32 +: 32] = 32'hCA00_0000 + 32'h0101_0101 * i;
   end

   tmr_bank_router #(.NUM_CORES(NC), .ADDR_W(AW)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_we_i(we),
      .bus_addr_i(addr), .bus_be_i(be), .bus_core_i(core), .bus_wdata_i(wdata),
      .bus_rdata_o(rdata), .bus_err_o(err), .bank_rd_o(rd), .bank_wr_o(wr),
      .bank_off_o(off), .bank_wdata_o(bwdata), .bank_rdata_i(brdata),
      .bank_irq_i(irq_in), .irq_o(irq_out)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   initial begin
      repeat (3000) @(posedge clk);
      if (!done) begin
         failures++; checks++;
         $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      // R9: reset state, illegal access presented during reset
      sel = 1'b1; addr = 9'h1E0;
      repeat (2) @(posedge clk);
      #2;
      check(err === 1'b0, "R9 reset err low", {31'd0, err}, 32'd0);
      @(negedge clk); sel = 1'b0; rst_n = 1'b1;
      @(posedge clk); #2;
      check(err === 1'b0, "R9 err low after reset", {31'd0, err}, 32'd0);

      for (int v = 0; v < NV; v++) begin
         logic [NC-1:0] exp_rd, exp_wr;
         logic [31:0]   exp_rdata;
         @(negedge clk);
         sel = VECS[v].sel; we = VECS[v].we; addr = VECS[v].addr;
         be = VECS[v].be; core = VECS[v].core; wdata = 32'h5A00_0000 + v;
         exp_rd = '0; exp_wr = '0; exp_rdata = '0;
         if (VECS[v].bank != 4'hF) begin
            if (VECS[v].we) exp_wr = NC'(1) << VECS[v].bank;
            else begin
               exp_rd = NC'(1) << VECS[v].bank;
               exp_rdata = 32'hCA00_0000 + 32'h0101_0101 * VECS[v].bank;
            end
         end
         #2;
         check(rd === exp_rd, $sformatf("R1/R2/R4/R6/R7/R8/R11 rd strobes v%0d", v), 32'(rd), 32'(exp_rd));
         check(wr === exp_wr, $sformatf("R1/R2/R4/R6/R7/R8/R11 wr strobes v%0d", v), 32'(wr), 32'(exp_wr));
         check(rdata === exp_rdata, $sformatf("R5 rdata v%0d", v), rdata, exp_rdata);
         check(off === VECS[v].addr[4:0], $sformatf("R3 offset v%0d", v), 32'(off), 32'(VECS[v].addr[4:0]));
         check(bwdata === wdata, $sformatf("R3 wdata v%0d", v), bwdata, wdata);
         @(posedge clk); #2;
         check(err === VECS[v].err, $sformatf("R9 err v%0d", v), {31'd0, err}, {31'd0, VECS[v].err});
      end

      // R10: interrupt pass-through
      for (int p = 0; p < 4; p++) begin
         logic [NC-1:0] pat;
         pat = (p == 0) ? 4'b0101 : (p == 1) ? 4'b1010 : (p == 2) ? 4'b1111 : 4'b0000;
         @(negedge clk); irq_in = pat; #2;
         check(irq_out === pat, "R10 irq order", 32'(irq_out), 32'(pat));
      end

      // R9: error clears after a legal access that follows an illegal one
      @(negedge clk); sel = 1'b1; we = 1'b0; addr = 9'h0C0; be = 4'hF; core = 3'd0;
      @(posedge clk); #2;
      check(err === 1'b1, "R9 err set", {31'd0, err}, 32'd1);
      @(negedge clk); addr = 9'h03C;
      #2;
      check(rdata === 32'hCA00_0000, "R2 win1 read after error", rdata, 32'hCA00_0000);
      @(posedge clk); #2;
      check(err === 1'b0, "R9 err cleared", {31'd0, err}, 32'd0);

      // R9: reset clears a pending error
      @(negedge clk); addr = 9'h1E0;
      @(posedge clk); #1; rst_n = 1'b0; #1;
      check(err === 1'b0, "R9 async reset clears err", {31'd0, err}, 32'd0);
      @(negedge clk); sel = 1'b0; rst_n = 1'b1;

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule